// File: doc/BRIEF.md
# Boot Mode Capture and External Interrupt Front End

This block sits behind a small group of shared input pins (two by default) that serve two purposes. While the chip is held in reset, the pins choose the boot operating mode. When reset is released, the mode register keeps the value the pins last had. From then on the pins act only as external interrupt request lines. Software may overwrite the mode register at any time once reset has ended.

Each request line has its own sensing choice. In falling-edge mode, a high-to-low transition sets a pending flag. The flag stays set until the matching acknowledge input clears it. In level mode, the request output follows the inverted, synchronized pin, and acknowledge has no effect on it. All pin sampling passes through a two-flop synchronizer. No request is raised during reset or during the first cycle after release, so a mode level that changes as reset ends cannot look like an interrupt.

Top module: `modepin_irq_front`

## Requirements
- R1: While `rst_n` is low, `boot_mode` takes the synchronized pin value. After release it keeps the value captured on the last reset clock edge. Pin bit i maps to `boot_mode` bit i.
- R2: After reset, changes on `pin_n` do not alter `boot_mode`.
- R3: Outside reset, a cycle with `mode_we` high loads `mode_wdata` into `boot_mode` at that clock edge. While `rst_n` is low, `mode_we` is ignored.
- R4: `irq_req` is all zeros while `rst_n` is low and during the first cycle after release. A falling pin seen in that first cycle does not set a pending flag.
- R5: When `edge_sel[i]` is 1 (falling-edge mode), a 1-to-0 transition on `pin_n[i]` sets `irq_req[i]`. The output rises three rising edges after the pin changes and stays high until it is acknowledged.
- R6: In edge mode, `irq_ack[i]` high at a clock edge clears the pending flag. If a new falling edge is detected at the same clock edge, the flag stays set.
- R7: When `edge_sel[i]` is 0 (level mode), `irq_req[i]` is the inverse of `pin_n[i]` delayed by two rising edges. `irq_ack[i]` has no effect in this mode.
- R8: In edge mode, a pin held low after its edge has been acknowledged raises no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode is captured while it is low |
| pin_n | input | N | Shared mode / active-low interrupt pins (asynchronous) |
| edge_sel | input | N | Per line: 1 = falling-edge sensing, 0 = level sensing |
| irq_ack | input | N | Per line acknowledge, clears an edge-mode pending flag |
| mode_we | input | 1 | Software write strobe for the mode register |
| mode_wdata | input | N | Value written to the mode register |
| boot_mode | output | N | Current operating mode |
| irq_req | output | N | Interrupt request per line |

## Verification
Two situations are hard to reach from the ports. The first is a pin that falls right at reset release. To create it, the bench drops the pins two clock edges before releasing reset. This timing places the synchronized falling edge in the first cycle after release, where it must be masked. The second is an acknowledge that arrives on the exact edge where a new falling edge is registered. The bench counts the pin change through both synchronizer stages and the edge history flop, then places the acknowledge on that edge. It checks that the pending flag survives.

// File: rtl/modepin_irq_front.sv
module modepin_irq_front #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] irq_ack,
  input  logic         mode_we,
  input  logic [N-1:0] mode_wdata,
  output logic [N-1:0] boot_mode,
  output logic [N-1:0] irq_req
);

  logic [N-1:0] sync_a, sync_b, hist, pend;
  logic         live;
  logic [N-1:0] fell;

  always_ff @(posedge clk) begin
    sync_a <= pin_n;
    sync_b <= sync_a;
    hist   <= sync_b;
  end

  assign fell = {N{live}} & hist & ~sync_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live      <= 1'b0;
      pend      <= '0;
      boot_mode <= sync_b;
    end else begin
      live <= 1'b1;
      pend <= edge_sel & (fell | (pend & ~irq_ack));
      if (mode_we) boot_mode <= mode_wdata;
    end
  end

  assign irq_req = (edge_sel & pend) | (~edge_sel & ~sync_b & {N{live}});

endmodule

// File: rtl/modepin_irq_front_chk.sv
module modepin_irq_front_chk #(
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pin_n,
  input logic [N-1:0] edge_sel,
  input logic [N-1:0] irq_ack,
  input logic         mode_we,
  input logic [N-1:0] mode_wdata,
  input logic [N-1:0] boot_mode,
  input logic [N-1:0] irq_req
);

  logic seen = 1'b0;
  logic was_rst = 1'b0;

  always_ff @(posedge clk) begin
    seen    <= 1'b1;
    was_rst <= !rst_n;
    if (seen && was_rst && !rst_n)
      p_quiet_reset_r4: assert (irq_req == '0)
        else $error("irq_req raised during reset");
  end

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(boot_mode));

  p_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> boot_mode == $past(mode_wdata));

  for (genvar i = 0; i < N; i++) begin : g_line
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[i] && irq_req[i] && !irq_ack[i]) |=> (irq_req[i] || !edge_sel[i]));

    p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_sel[i] && $past(rst_n)) |-> irq_req[i] == !$past(pin_n[i], 2));
  end

endmodule

bind modepin_irq_front modepin_irq_front_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .edge_sel(edge_sel),
  .irq_ack(irq_ack), .mode_we(mode_we), .mode_wdata(mode_wdata),
  .boot_mode(boot_mode), .irq_req(irq_req)
);

// File: tb/modepin_irq_front_test.sv
module modepin_irq_front_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_n = 2'b11;
  logic [1:0] edge_sel = 2'b00;
  logic [1:0] irq_ack = 2'b00;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic [1:0] boot_mode, irq_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  modepin_irq_front #(.N(2)) uut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .edge_sel(edge_sel),
    .irq_ack(irq_ack), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .boot_mode(boot_mode), .irq_req(irq_req)
  );

  // {pin_n, irq_ack, expected irq_req}; line 0 edge mode, line 1 level mode
  localparam logic [5:0] VEC [17] = '{
    6'b11_00_00, 6'b10_00_00, 6'b10_00_00, 6'b11_00_01, 6'b11_00_01,
    6'b11_01_00, 6'b01_00_00, 6'b01_10_10, 6'b11_00_10, 6'b11_00_00,
    6'b10_00_00, 6'b10_00_00, 6'b10_01_01, 6'b10_00_01, 6'b10_01_00,
    6'b10_00_00, 6'b11_00_00
  };

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset with pins 11, line 0 edge, line 1 level
    edge_sel = 2'b01;
    pin_n = 2'b11;
    repeat (5) tick();
    chk("R4 quiet in reset", irq_req, 2'b00);
    rst_n = 1'b1;
    tick();
    chk("R1 mode captured", boot_mode, 2'b11);
    tick();
    tick();

    // vector walk, R5/R6/R7/R8
    for (int k = 0; k < 17; k++) begin
      pin_n   = VEC[k][5:4];
      irq_ack = VEC[k][3:2];
      tick();
      chk($sformatf("R5/R6/R7/R8 row %0d", k), irq_req, VEC[k][1:0]);
    end
    irq_ack = 2'b00;

    chk("R2 mode unaffected by pins", boot_mode, 2'b11);

    mode_we = 1'b1;
    mode_wdata = 2'b01;
    tick();
    mode_we = 1'b0;
    chk("R3 software write", boot_mode, 2'b01);

    // reset: level mode, pins 10, write attempted during reset
    rst_n = 1'b0;
    edge_sel = 2'b00;
    pin_n = 2'b10;
    mode_we = 1'b1;
    mode_wdata = 2'b01;
    repeat (5) tick();
    chk("R4 level line low in reset", irq_req, 2'b00);
    chk("R3 write ignored in reset", boot_mode, 2'b10);
    mode_we = 1'b0;
    rst_n = 1'b1;
    #1;
    chk("R4 first cycle after release", irq_req, 2'b00);
    #4;
    tick();
    chk("R7 level request after release", irq_req, 2'b01);
    chk("R1 mode kept after release", boot_mode, 2'b10);

    // false edge at release: pins drop two edges before release
    rst_n = 1'b0;
    edge_sel = 2'b11;
    pin_n = 2'b11;
    repeat (5) tick();
    pin_n = 2'b00;
    tick();
    tick();
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R4 no false edge at release", irq_req, 2'b00);
    end
    chk("R1 mode from pins before drop", boot_mode, 2'b11);

    // fresh edge after release still works, R5
    pin_n = 2'b11;
    repeat (3) tick();
    pin_n = 2'b01;
    tick();
    tick();
    chk("R5 not yet visible", irq_req, 2'b00);
    tick();
    chk("R5 pending set", irq_req, 2'b10);
    irq_ack = 2'b10;
    tick();
    irq_ack = 2'b00;
    chk("R6 ack clears", irq_req, 2'b00);
    chk("R2 mode still held", boot_mode, 2'b11);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule